// File: doc/BRIEF.md
# Forwarded-Clock Parallel Word Serializer

This block takes a 24-bit parallel word, latched on the rising edge of an external strobe, and sends it on a single serial data line. A forwarded serial clock goes out with the data. The strobe runs in its own timing domain and is slower than the reference clock. A single-entry holding stage carries each strobed word into the reference-clock domain through a two-flop toggle handshake. The reference clock is modelled as a system clock `clk` with a bit-rate enable `bit_en`: each cycle in which the enable is high advances the serial stream by one bit time.

Each serial frame lasts 26 bit times. It begins with a start bit of 1 and a stop bit of 0, then carries the 24 data bits, least significant first. The forwarded clock toggles on every bit boundary, on the same cycle as the data, so its edges line up with the data edges. When no word is waiting, the block sends idle frames with all data bits at zero, so that a receiver keeps frame lock.

Three mode pins (a direction pin and two select pins) choose one of three states: serializer, deserializer, or a disabled reset state. In the reset state the pad output enables drop, so the pad ring tri-states the outputs. An inverted copy of the direction pin is driven on a separate control output.

Top module: `fwd_word_serializer`

## Requirements
- R1: The value on `par_in` at a rising edge of `strobe`, taken in serializer mode, is sent in the frame that begins at the next frame boundary after the word reaches the clock domain. `par_in[0]` is data bit 1.
- R2: A frame is 26 bit times long. Bit time 0 is the start bit (1), bit time 1 is the stop bit (0), and bit times 2 to 25 carry `par_in[0]` to `par_in[23]` in that order.
- R3: `ser_clk` toggles exactly on the cycles where `bit_en` is high in serializer mode, and it is 0 during every start bit. On cycles without `bit_en`, both `ser_clk` and `ser_data` hold their values.
- R4: When no word is waiting at a frame boundary, the next frame is an idle frame: start bit 1, stop bit 0, and 24 zero data bits.
- R5: If a second strobe arrives before the waiting word has been loaded into a frame, the newer word replaces it and `overrun` is set. `overrun` then stays set until the block leaves the serializer and deserializer modes.
- R6: Mode code direction=x, S1=0, S2=0 (`mode_a`=0, `mode_b`=0) is the reset state: `ser_oe`=0 and `ctl_oe`=0, `overrun` is cleared, and any waiting word is dropped. This holds for either value of the direction pin.
- R7: Code direction=1, `mode_a`=0, `mode_b`=1 selects serializer mode: `ser_oe`=1 and `ctl_oe`=1. Framing restarts at the start bit with `ser_clk`=0 and the first frame idle.
- R8: Code direction=0, `mode_a`=1, `mode_b`=0 selects deserializer mode: `ser_oe`=0 and `ctl_oe`=1. Strobes taken in this mode are never sent. Any other code behaves like the reset state.
- R9: `dir_n_out` is always the inverse of `dir_sel`.
- R10: A word is loaded only at a frame boundary. A strobe taken in the middle of a frame does not change the frame in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference-domain clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | Bit-rate enable; one bit time per high cycle |
| strobe | input | 1 | Word capture strobe, rising edge |
| par_in | input | 24 | Parallel data word |
| dir_sel | input | 1 | Direction pin (1 = serialize) |
| mode_a | input | 1 | Mode select pin S1 |
| mode_b | input | 1 | Mode select pin S2 |
| ser_data | output | 1 | Serial data |
| ser_clk | output | 1 | Forwarded serial clock, edge-aligned with data |
| ser_oe | output | 1 | Pad enable for the serial outputs |
| ctl_oe | output | 1 | Pad enable for the control output |
| dir_n_out | output | 1 | Inverted copy of `dir_sel` |
| overrun | output | 1 | Sticky flag: a waiting word was overwritten |

## Verification
The bench builds the block at the full 24-bit word width, so each frame is 26 bits. With that build, it sends a walking one through every data position and then several dense patterns, and each frame is compared bit by bit against a frame computed arithmetically in the bench. It places `bit_en` on alternate cycles, which makes the hold-between-enables behaviour visible. It places strobes in mid-frame, which shows the boundary-only load. It also covers double strobes, idle frames, deserializer-mode strobes, an invalid mode code, and the reset code with the direction pin high.

// File: rtl/fws_pkg.sv
package fws_pkg;
  typedef enum logic [1:0] {
    MODE_OFF = 2'd0,
    MODE_SER = 2'd1,
    MODE_DES = 2'd2
  } fws_mode_e;

  // Only the two exact codes select a function; all others are off.
  function automatic fws_mode_e decode_mode(input logic dir, input logic sa, input logic sb);
    if (dir && !sa && sb)      return MODE_SER;
    else if (!dir && sa && !sb) return MODE_DES;
    else                        return MODE_OFF;
  endfunction
endpackage

// File: rtl/fws_strobe_latch.sv
module fws_strobe_latch #(
  parameter int WORD_W = 24
) (
  input  logic              strobe,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] par_in,
  output logic [WORD_W-1:0] hold_word,
  output logic              hold_tgl
);
  always_ff @(posedge strobe or negedge rst_n) begin
    if (!rst_n) begin
      hold_word <= '0;
      hold_tgl  <= 1'b0;
    end else begin
      hold_word <= par_in;
      hold_tgl  <= ~hold_tgl;
    end
  end
endmodule

// File: rtl/fws_word_sync.sv
module fws_word_sync #(
  parameter int WORD_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold_tgl,
  input  logic [WORD_W-1:0] hold_word,
  input  logic              ser_active,
  input  logic              mode_off,
  input  logic              take,
  output logic              new_word,
  output logic              pend_valid,
  output logic [WORD_W-1:0] pend_word,
  output logic              overrun
);
  logic [2:0] tgl_sync;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tgl_sync <= '0;
    else        tgl_sync <= {tgl_sync[1:0], hold_tgl};
  end

  // Toggle edge: the holding word has been stable for two flop stages.
  assign new_word = tgl_sync[2] ^ tgl_sync[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_valid <= 1'b0;
      pend_word  <= '0;
      overrun    <= 1'b0;
    end else if (!ser_active) begin
      pend_valid <= 1'b0;
      if (mode_off) overrun <= 1'b0;
    end else if (new_word) begin
      pend_word  <= hold_word;
      pend_valid <= 1'b1;
      if (pend_valid && !take) overrun <= 1'b1;
    end else if (take) begin
      pend_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/fws_framer.sv
module fws_framer #(
  parameter int WORD_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic              ser_active,
  input  logic              pend_valid,
  input  logic [WORD_W-1:0] pend_word,
  output logic              take,
  output logic [$clog2(WORD_W+2)-1:0] bit_idx,
  output logic              ser_data,
  output logic              ser_clk
);
  localparam int FRAME_LEN = WORD_W + 2;
  localparam int IDX_W     = $clog2(FRAME_LEN);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(FRAME_LEN - 1);

  logic [WORD_W-1:0] cur_word;

  // Bit time 0 start (1), 1 stop (0), then data LSB first.
  function automatic logic frame_bit(input logic [WORD_W-1:0] w, input logic [IDX_W-1:0] k);
    if (k == '0)               return 1'b1;
    else if (k == IDX_W'(1))   return 1'b0;
    else                       return w[k - IDX_W'(2)];
  endfunction

  assign take     = ser_active && bit_en && (bit_idx == LAST) && pend_valid;
  assign ser_data = frame_bit(cur_word, bit_idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_idx  <= '0;
      cur_word <= '0;
      ser_clk  <= 1'b0;
    end else if (!ser_active) begin
      bit_idx  <= '0;
      cur_word <= '0;
      ser_clk  <= 1'b0;
    end else if (bit_en) begin
      ser_clk <= ~ser_clk;
      if (bit_idx == LAST) begin
        bit_idx  <= '0;
        cur_word <= pend_valid ? pend_word : '0;
      end else begin
        bit_idx <= bit_idx + IDX_W'(1);
      end
    end
  end
endmodule

// File: rtl/fwd_word_serializer.sv
module fwd_word_serializer #(
  parameter int WORD_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic              strobe,
  input  logic [WORD_W-1:0] par_in,
  input  logic              dir_sel,
  input  logic              mode_a,
  input  logic              mode_b,
  output logic              ser_data,
  output logic              ser_clk,
  output logic              ser_oe,
  output logic              ctl_oe,
  output logic              dir_n_out,
  output logic              overrun
);
  import fws_pkg::*;

  localparam int FRAME_LEN = WORD_W + 2;
  localparam int IDX_W     = $clog2(FRAME_LEN);

  fws_mode_e         mode_q;
  logic              ser_active, mode_off;
  logic [WORD_W-1:0] hold_word, pend_word;
  logic              hold_tgl, new_word, pend_valid, load_pulse;
  logic [IDX_W-1:0]  bit_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= MODE_OFF;
    else        mode_q <= decode_mode(dir_sel, mode_a, mode_b);
  end

  assign ser_active = (mode_q == MODE_SER);
  assign mode_off   = (mode_q == MODE_OFF);
  assign ser_oe     = ser_active;
  assign ctl_oe     = !mode_off;
  assign dir_n_out  = ~dir_sel;

  fws_strobe_latch #(.WORD_W(WORD_W)) u_latch (
    .strobe(strobe), .rst_n(rst_n), .par_in(par_in),
    .hold_word(hold_word), .hold_tgl(hold_tgl)
  );

  fws_word_sync #(.WORD_W(WORD_W)) u_sync (
    .clk(clk), .rst_n(rst_n), .hold_tgl(hold_tgl), .hold_word(hold_word),
    .ser_active(ser_active), .mode_off(mode_off), .take(load_pulse),
    .new_word(new_word), .pend_valid(pend_valid), .pend_word(pend_word),
    .overrun(overrun)
  );

  fws_framer #(.WORD_W(WORD_W)) u_framer (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .ser_active(ser_active),
    .pend_valid(pend_valid), .pend_word(pend_word), .take(load_pulse),
    .bit_idx(bit_idx), .ser_data(ser_data), .ser_clk(ser_clk)
  );
endmodule

// File: rtl/fws_checker.sv
module fws_checker #(
  parameter int FRAME_LEN = 26,
  parameter int IDX_W     = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bit_en,
  input logic             ser_oe,
  input logic             ser_clk,
  input logic             ser_data,
  input logic             overrun,
  input logic             mode_off,
  input logic             load_pulse,
  input logic [IDX_W-1:0] bit_idx
);
  assert_clk_follows_enable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_oe && $past(ser_oe)) |-> ((ser_clk != $past(ser_clk)) == $past(bit_en)));

  assert_clk_low_on_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_oe && bit_idx == '0) |-> !ser_clk);

  assert_start_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_oe && bit_idx == '0) |-> ser_data);

  assert_stop_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_oe && bit_idx == IDX_W'(1)) |-> !ser_data);

  assert_load_at_boundary_R10: assert property (@(posedge clk) disable iff (!rst_n)
    load_pulse |=> (bit_idx == '0));

  assert_overrun_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!overrun && $past(overrun)) |-> $past(mode_off));

  assert_overrun_only_serial_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> $past(ser_oe));

  assert_entry_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_oe && !$past(ser_oe)) |-> (bit_idx == '0 && !ser_clk));
endmodule

bind fwd_word_serializer fws_checker #(.FRAME_LEN(FRAME_LEN), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .ser_oe(ser_oe), .ser_clk(ser_clk),
  .ser_data(ser_data), .overrun(overrun), .mode_off(mode_off),
  .load_pulse(load_pulse), .bit_idx(bit_idx)
);

// File: tb/sim_fwd_word_serializer.sv
`timescale 1ns/1ps
module sim_fwd_word_serializer;
  localparam int W = 24;
  localparam int FL = W + 2;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0, bit_en = 1'b0, strobe = 1'b0;
  logic [W-1:0] par_in = '0;
  logic dir_sel = 1'b0, mode_a = 1'b0, mode_b = 1'b0;
  logic ser_data, ser_clk, ser_oe, ctl_oe, dir_n_out, overrun;
  int errors = 0, checks = 0;
  bit done = 1'b0;

  fwd_word_serializer u0 (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .strobe(strobe), .par_in(par_in),
    .dir_sel(dir_sel), .mode_a(mode_a), .mode_b(mode_b), .ser_data(ser_data),
    .ser_clk(ser_clk), .ser_oe(ser_oe), .ctl_oe(ctl_oe), .dir_n_out(dir_n_out),
    .overrun(overrun)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic exp_bit(input logic [W-1:0] w, input int k);
    if (k == 0) return 1'b1;
    if (k == 1) return 1'b0;
    return w[k-2];
  endfunction

  task automatic pulse(input logic [W-1:0] w);
    par_in = w;
    #1 strobe = 1'b1;
    #6 strobe = 1'b0;
    #1;
    @(negedge clk);
  endtask

  task automatic set_mode(input logic d, input logic a, input logic b);
    dir_sel = d; mode_a = a; mode_b = b;
    repeat (2) @(negedge clk);
  endtask

  // Receives one frame; optional strobes at bit positions s1 and s2 (-1 = none).
  task automatic recv_frame(input logic [W-1:0] expw, input string req,
                            input int s1, input logic [W-1:0] w1,
                            input int s2, input logic [W-1:0] w2);
    int dbad = 0, cbad = 0;
    logic [W-1:0] got = '0;
    logic sc;
    for (int k = 0; k < FL; k++) begin
      if (k == s1) pulse(w1);
      if (k == s2) pulse(w2);
      if (ser_data !== exp_bit(expw, k)) dbad++;
      if (ser_clk !== k[0]) cbad++;
      if (k >= 2) got[k-2] = ser_data;
      bit_en = 1'b1;
      @(negedge clk);
      bit_en = 1'b0;
      sc = ser_clk;
      @(negedge clk);
      if (ser_clk !== sc) cbad++;
    end
    chk(dbad == 0, {req, " R2 frame"}, got, expw);
    chk(cbad == 0, "R3 forwarded clock", cbad, 0);
  endtask

  initial begin
    logic [W-1:0] prev;
    repeat (3) @(negedge clk);
    chk(ser_oe == 1'b0 && ctl_oe == 1'b0, "R6 reset outputs off", {ser_oe, ctl_oe}, 0);
    chk(overrun == 1'b0, "R6 overrun clear", overrun, 0);
    rst_n = 1'b1;
    @(negedge clk);

    set_mode(1'b0, 1'b1, 1'b0);
    chk(ser_oe == 1'b0 && ctl_oe == 1'b1, "R8 deserializer enables", {ser_oe, ctl_oe}, 1);
    chk(dir_n_out == 1'b1, "R9 dir inverse (dir=0)", dir_n_out, 1);
    pulse(24'hABCDEF);
    repeat (8) @(negedge clk);

    set_mode(1'b1, 1'b0, 1'b1);
    chk(ser_oe == 1'b1 && ctl_oe == 1'b1, "R7 serializer enables", {ser_oe, ctl_oe}, 3);
    chk(dir_n_out == 1'b0, "R9 dir inverse (dir=1)", dir_n_out, 0);
    // First frame idle (R8: deserializer-mode strobe dropped); mid-frame strobe waits (R10).
    prev = 24'h000001;
    recv_frame('0, "R8 R10 idle first", 3, prev, -1, '0);
    for (int i = 1; i < W; i++) begin
      recv_frame(prev, "R1 walking one", 3, 24'(1) << i, -1, '0);
      prev = 24'(1) << i;
    end
    recv_frame(prev, "R1 walking one", 3, 24'hFFFFFF, -1, '0);
    recv_frame(24'hFFFFFF, "R1 all ones", 3, 24'hA5A5A5, -1, '0);
    recv_frame(24'hA5A5A5, "R1 pattern", 3, 24'h5A5A5A, -1, '0);
    recv_frame(24'h5A5A5A, "R1 pattern", -1, '0, -1, '0);
    recv_frame('0, "R4 idle", -1, '0, -1, '0);
    chk(overrun == 1'b0, "R5 no overrun on single strobes", overrun, 0);
    recv_frame('0, "R4 idle", 4, 24'h123456, 10, 24'h654321);
    chk(overrun == 1'b1, "R5 overrun set", overrun, 1);
    recv_frame(24'h654321, "R5 newer word kept", -1, '0, -1, '0);
    chk(overrun == 1'b1, "R5 overrun sticky", overrun, 1);

    set_mode(1'b1, 1'b1, 1'b1);
    chk(ser_oe == 1'b0 && ctl_oe == 1'b0, "R8 invalid code off", {ser_oe, ctl_oe}, 0);
    chk(overrun == 1'b0, "R6 overrun cleared", overrun, 0);

    set_mode(1'b1, 1'b0, 1'b1);
    recv_frame('0, "R4 idle", 5, 24'h0F0F0F, -1, '0);
    set_mode(1'b1, 1'b0, 1'b0);
    chk(ser_oe == 1'b0 && ctl_oe == 1'b0, "R6 reset code dir=1", {ser_oe, ctl_oe}, 0);

    set_mode(1'b1, 1'b0, 1'b1);
    chk(ser_clk == 1'b0 && ser_data == 1'b1, "R7 restart at start bit", {ser_clk, ser_data}, 1);
    recv_frame('0, "R6 pending dropped", 5, 24'h00F00D, -1, '0);
    recv_frame(24'h00F00D, "R1 after restart", -1, '0, -1, '0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule